// File: doc/BRIEF.md
# Processor Processing-State Supervisor

This block keeps track of the processing state a CPU core is in and tells the rest of the core whether it may use the bus. There are three top-level states: normal execution, exception processing and halted. Normal execution has one sub-state, stopped, which a stop instruction enters. The state code separates all four, so stopped and halted are never confused. A bus error that arrives while a bus-error exception is already being handled counts as a double fault. It latches the halted state, and only an accepted external reset clears it.

The external reset and halt lines are qualified by a hold counter. A reset is accepted only after both lines have been high together for `HOLD_CYCLES` consecutive clocks. Until the first reset has been accepted after power-up, the required hold is `POR_HOLD_CYCLES`, which stands in for a 100 ms power-up minimum. An accepted reset produces a one-cycle core-reset pulse. The state machine then enters exception processing, and from there the core returns to normal execution when `exc_done` is seen.

State machine: `ST_NORMAL` (code 00), `ST_STOPPED` (01), `ST_EXCEPT` (10), `ST_HALTED` (11). Transitions:
- NORMAL→STOPPED on stop.
- NORMAL→EXCEPT on a bus error, an interrupt or an internal request.
- STOPPED→EXCEPT on an interrupt.
- EXCEPT→NORMAL on exception done.
- EXCEPT→HALTED on a double bus fault.
- Any state→EXCEPT on an accepted reset.
- Power-up→HALTED.

Top module: `cpu_state_supervisor`

## Requirements
- R1: While `por_n` is low and afterwards, until the first accepted reset, `state_code` is 11 (halted) and `bus_req_en` is 0.
- R2: In normal (00), a `stop_req` with no bus error, interrupt or internal request moves the state to stopped (01) on the next clock.
- R3: Stopped is left only by `irq_req` (to 10) or by an accepted reset. `exc_req`, `bus_err`, `stop_req` and `exc_done` leave it at 01.
- R4: In normal, `bus_err`, `irq_req` or `exc_req` moves the state to exception (10) on the next clock. Each of these takes priority over `stop_req`.
- R5: In exception, `exc_done` without `bus_err` returns the state to normal (00) and clears the bus-error-in-progress mark. A later single bus error therefore does not halt.
- R6: A `bus_err` during exception processing that was itself entered by a bus error moves the state to halted (11). A first `bus_err` during any other exception processing keeps the state at 10 and marks it as bus-error processing.
- R7: Halted (11) is kept under any combination of `stop_req`, `exc_req`, `irq_req`, `bus_err` and `exc_done`.
- R8: Once power-up is complete, `core_reset` pulses high for exactly one cycle. The pulse comes in the cycle after the `HOLD_CYCLES`-th consecutive clock with both `ext_reset` and `ext_halt` high. It fires once per hold, however long the hold lasts. On the next clock, the state becomes exception (10) from any state.
- R9: If either line drops before the required count is reached, the hold count restarts from zero, and no pulse is produced for that hold.
- R10: The first reset after power-up needs `POR_HOLD_CYCLES` consecutive cycles. A hold of `HOLD_CYCLES` is not enough then.
- R11: `bus_req_en` is 1 in normal and exception, and 0 in stopped and halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| stop_req | input | 1 | Stop instruction executed |
| exc_req | input | 1 | Internal exception request (trap, trace) |
| irq_req | input | 1 | Interrupt request |
| bus_err | input | 1 | Bus error |
| exc_done | input | 1 | Exception processing finished |
| ext_reset | input | 1 | External reset line, active high |
| ext_halt | input | 1 | External halt line, active high |
| state_code | output | 2 | 00 normal, 01 stopped, 10 exception, 11 halted |
| bus_req_en | output | 1 | Core may issue bus references |
| core_reset | output | 1 | One-cycle accepted-reset pulse |

## Verification
The assertions assume that all inputs are synchronous to `clk` and are stable around its rising edge. The double-fault and reset properties also assume that `por_n` is released only once, so the "powered" history is not reset mid-run. The bench drives every input shortly after a falling edge and holds it for a full cycle. It releases `por_n` once at the start. Its reset holds are built from whole cycles of both lines high, so the hold count it expects is exact.

// File: rtl/pss_pkg.sv
package pss_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'b00,
        ST_STOPPED = 2'b01,
        ST_EXCEPT  = 2'b10,
        ST_HALTED  = 2'b11
    } pss_state_e;
endpackage

// File: rtl/pss_reset_qual.sv
module pss_reset_qual #(
    parameter int HOLD_CYCLES     = 10,
    parameter int POR_HOLD_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic por_n,
    input  logic ext_reset,
    input  logic ext_halt,
    output logic core_reset
);
    localparam int CW = $clog2(POR_HOLD_CYCLES + 1);
    localparam logic [CW-1:0] NEED_RUN = CW'(HOLD_CYCLES);
    localparam logic [CW-1:0] NEED_POR = CW'(POR_HOLD_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          powered_q;
    logic          pulse_q;
    logic          both_high;
    logic [CW-1:0] need;

    assign both_high  = ext_reset && ext_halt;
    assign need       = powered_q ? NEED_RUN : NEED_POR;
    assign core_reset = pulse_q;

    // The count saturates at the required value, so a long hold pulses only once.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q     <= '0;
            powered_q <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (!both_high) begin
                cnt_q <= '0;
            end else if (cnt_q < need) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == need - 1'b1) begin
                    pulse_q   <= 1'b1;
                    powered_q <= 1'b1;
                end
            end
        end
    end

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!por_n)
        core_reset |=> !core_reset);
    assert_pulse_after_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_reset) |-> $past(both_high));
    assert_no_pulse_on_drop_R9: assert property (@(posedge clk) disable iff (!por_n)
        !both_high |=> !core_reset);
endmodule

// File: rtl/pss_state_fsm.sv
module pss_state_fsm
    import pss_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       stop_req,
    input  logic       exc_req,
    input  logic       irq_req,
    input  logic       bus_err,
    input  logic       exc_done,
    input  logic       core_reset,
    output logic [1:0] state_code,
    output logic       bus_req_en
);
    pss_state_e state_q, state_d;
    logic       berr_q, berr_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_HALTED;
            berr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            berr_q  <= berr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        berr_d  = berr_q;
        if (core_reset) begin
            state_d = ST_EXCEPT;
            berr_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_NORMAL: begin
                    if (bus_err) begin
                        state_d = ST_EXCEPT;
                        berr_d  = 1'b1;
                    end else if (irq_req || exc_req) begin
                        state_d = ST_EXCEPT;
                    end else if (stop_req) begin
                        state_d = ST_STOPPED;
                    end
                end
                ST_STOPPED: begin
                    if (irq_req) state_d = ST_EXCEPT;
                end
                ST_EXCEPT: begin
                    if (bus_err) begin
                        if (berr_q) state_d = ST_HALTED;
                        else        berr_d  = 1'b1;
                    end else if (exc_done) begin
                        state_d = ST_NORMAL;
                        berr_d  = 1'b0;
                    end
                end
                ST_HALTED: begin
                    state_d = ST_HALTED;
                end
                default: state_d = ST_HALTED;
            endcase
        end
    end

    always_comb begin
        state_code = state_q;
        unique case (state_q)
            ST_NORMAL, ST_EXCEPT:   bus_req_en = 1'b1;
            ST_STOPPED, ST_HALTED:  bus_req_en = 1'b0;
            default:                bus_req_en = 1'b0;
        endcase
    end

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_HALTED && !core_reset) |=> state_q == ST_HALTED);
    assert_double_fault_R6: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_EXCEPT && berr_q && bus_err && !core_reset) |=> state_q == ST_HALTED);
    assert_reset_to_exc_R8: assert property (@(posedge clk) disable iff (!por_n)
        core_reset |=> (state_q == ST_EXCEPT && !berr_q));
    assert_stop_holds_R3: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_STOPPED && !irq_req && !core_reset) |=> state_q == ST_STOPPED);
    assert_halt_only_from_exc_R6: assert property (@(posedge clk) disable iff (!por_n)
        $rose(state_q == ST_HALTED) |-> $past(state_q == ST_EXCEPT && bus_err));
endmodule

// File: rtl/cpu_state_supervisor.sv
module cpu_state_supervisor #(
    parameter int HOLD_CYCLES     = 10,
    parameter int POR_HOLD_CYCLES = 25_000_000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       stop_req,
    input  logic       exc_req,
    input  logic       irq_req,
    input  logic       bus_err,
    input  logic       exc_done,
    input  logic       ext_reset,
    input  logic       ext_halt,
    output logic [1:0] state_code,
    output logic       bus_req_en,
    output logic       core_reset
);
    logic rst_pulse;

    pss_reset_qual #(
        .HOLD_CYCLES    (HOLD_CYCLES),
        .POR_HOLD_CYCLES(POR_HOLD_CYCLES)
    ) u_qual (
        .clk       (clk),
        .por_n     (por_n),
        .ext_reset (ext_reset),
        .ext_halt  (ext_halt),
        .core_reset(rst_pulse)
    );

    pss_state_fsm u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .stop_req  (stop_req),
        .exc_req   (exc_req),
        .irq_req   (irq_req),
        .bus_err   (bus_err),
        .exc_done  (exc_done),
        .core_reset(rst_pulse),
        .state_code(state_code),
        .bus_req_en(bus_req_en)
    );

    assign core_reset = rst_pulse;

    assert_bus_off_R11: assert property (@(posedge clk) disable iff (!por_n)
        (state_code == 2'b01 || state_code == 2'b11) |-> !bus_req_en);
endmodule

// File: tb/cpu_state_supervisor_tb.sv
module cpu_state_supervisor_tb;
    localparam int HOLD = 10;
    localparam int PORH = 30;
    localparam logic [1:0] NRM = 2'b00, STP = 2'b01, EXC = 2'b10, HLT = 2'b11;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic stop_req = 0, exc_req = 0, irq_req = 0, bus_err = 0, exc_done = 0;
    logic ext_reset = 0, ext_halt = 0;
    logic [1:0] state_code;
    logic bus_req_en, core_reset;

    always #2 clk = ~clk;

    cpu_state_supervisor #(.HOLD_CYCLES(HOLD), .POR_HOLD_CYCLES(PORH)) u_dut (
        .clk(clk), .por_n(por_n), .stop_req(stop_req), .exc_req(exc_req),
        .irq_req(irq_req), .bus_err(bus_err), .exc_done(exc_done),
        .ext_reset(ext_reset), .ext_halt(ext_halt),
        .state_code(state_code), .bus_req_en(bus_req_en), .core_reset(core_reset)
    );

    typedef struct {
        logic [1:0] st;
        logic       pls;
        string      req;
    } exp_t;

    exp_t sb_q[$];
    exp_t it;
    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;

    // Monitor: compares each output sample with the oldest expectation.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            logic exp_bre;
            it = sb_q.pop_front();
            exp_bre = (it.st == NRM) || (it.st == EXC);
            n_cmp++;
            if (state_code !== it.st || core_reset !== it.pls || bus_req_en !== exp_bre) begin
                n_bad++;
                $display("FAIL %s: state=%b pulse=%b bus_en=%b expected state=%b pulse=%b bus_en=%b",
                         it.req, state_code, core_reset, bus_req_en, it.st, it.pls, exp_bre);
            end
        end
    end

    task automatic apply(input logic s, input logic e, input logic i, input logic b,
                         input logic d, input logic r, input logic h,
                         input logic [1:0] est, input logic ep, input string req);
        exp_t x;
        @(negedge clk);
        #1;
        stop_req = s; exc_req = e; irq_req = i; bus_err = b; exc_done = d;
        ext_reset = r; ext_halt = h;
        x.st = est; x.pls = ep; x.req = req;
        sb_q.push_back(x);
    endtask

    // Holds both lines for n cycles, then releases them for one cycle.
    task automatic hold(input int n, input int need, input logic [1:0] st0, input string req);
        for (int k = 1; k <= n; k++)
            apply(0, 0, 0, 0, 0, 1, 1, (k > need) ? EXC : st0, (k == need), req);
        apply(0, 0, 0, 0, 0, 0, 0, (n >= need) ? EXC : st0, 1'b0, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 por_n = 1'b1;
        apply(0, 0, 0, 0, 0, 0, 0, HLT, 0, "R1");
        apply(1, 1, 1, 1, 1, 0, 0, HLT, 0, "R1");
        // R10: a short hold before power-up completes is not enough
        hold(20, PORH, HLT, "R10");
        // R9: count restarted, full power-up hold accepted
        hold(PORH, PORH, HLT, "R9");
        apply(0, 0, 0, 0, 1, 0, 0, NRM, 0, "R5");
        apply(1, 0, 0, 0, 0, 0, 0, STP, 0, "R2");
        apply(0, 1, 0, 0, 0, 0, 0, STP, 0, "R3");
        apply(0, 0, 0, 1, 0, 0, 0, STP, 0, "R3");
        apply(1, 0, 0, 0, 1, 0, 0, STP, 0, "R3");
        apply(0, 0, 1, 0, 0, 0, 0, EXC, 0, "R3");
        apply(0, 0, 0, 0, 1, 0, 0, NRM, 0, "R5");
        apply(0, 1, 0, 0, 0, 0, 0, EXC, 0, "R4");
        apply(0, 0, 0, 0, 1, 0, 0, NRM, 0, "R5");
        apply(1, 0, 1, 0, 0, 0, 0, EXC, 0, "R4");
        apply(0, 0, 0, 0, 1, 0, 0, NRM, 0, "R5");
        apply(0, 0, 0, 1, 0, 0, 0, EXC, 0, "R4");
        apply(0, 0, 0, 0, 1, 0, 0, NRM, 0, "R5");
        apply(0, 0, 0, 1, 0, 0, 0, EXC, 0, "R5");
        apply(0, 0, 0, 1, 0, 0, 0, HLT, 0, "R6");
        apply(1, 1, 1, 1, 1, 0, 0, HLT, 0, "R7");
        apply(0, 0, 1, 0, 0, 0, 0, HLT, 0, "R7");
        apply(0, 0, 0, 0, 1, 0, 0, HLT, 0, "R7");
        hold(HOLD - 1, HOLD, HLT, "R9");
        hold(HOLD, HOLD, HLT, "R8");
        // R6: first bus error inside a reset exception only marks it
        apply(0, 0, 0, 1, 0, 0, 0, EXC, 0, "R6");
        apply(0, 0, 0, 1, 0, 0, 0, HLT, 0, "R6");
        hold(HOLD, HOLD, HLT, "R8");
        apply(0, 0, 0, 0, 1, 0, 0, NRM, 0, "R5");
        apply(1, 0, 0, 0, 0, 0, 0, STP, 0, "R2");
        hold(HOLD + 3, HOLD, STP, "R8");
        apply(0, 1, 0, 0, 0, 0, 0, EXC, 0, "R6");
        apply(0, 0, 0, 1, 0, 0, 0, EXC, 0, "R6");
        apply(0, 0, 0, 1, 0, 0, 0, HLT, 0, "R6");
        hold(HOLD, HOLD, HLT, "R8");
        apply(0, 0, 0, 0, 1, 0, 0, NRM, 0, "R11");
        hold(HOLD, HOLD, NRM, "R8");
        apply(0, 0, 0, 0, 0, 0, 0, EXC, 0, "R11");
        repeat (3) @(negedge clk);
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule